// File: doc/BRIEF.md
# Register Dependency Scoreboard

This block decides, in a single cycle, whether an instruction offered by an in-order issue stage may go on to the execution queue. It keeps, for each hardware thread, busy bits over the thread's general registers, its flag registers and its address (index) registers. An offered instruction is compared with the busy bits of its own thread. If nothing conflicts, `iss_ready` is high, and the offer together with that ready counts as an issue. If something conflicts, `iss_ready` is low and the issue stage holds the instruction until the bits that block it are cleared.

Every thread has its own hazard test, built in parallel with the others. The issuing thread's tag selects which result reaches `iss_ready`.

An issued instruction marks its destination registers busy for writing. A message send also marks its payload registers busy for reading, because the payload must stay unchanged until it has been streamed out. Each kind of mark has its own clear input: one for result writebacks, one for payload-read completions, one for flag writebacks and one for address-register writebacks. Two hint bits come with each instruction. One skips the hazard test. The other keeps the instruction's destinations from being marked.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every busy bit of every thread is clear, so any offered instruction sees `iss_ready` high.
- R2: A read-after-write stall drops `iss_ready`. This happens when source A, source B, or any register of the source range (`iss_pay_base`, `iss_pay_len`) is write-busy in the issuing thread.
- R3: A write-after-write stall drops `iss_ready`. This happens when any register of the destination range (`iss_dst_base`, `iss_dst_len`) is write-busy in the issuing thread.
- R4: A write-after-read stall drops `iss_ready`. This happens when any register of the destination range is read-busy, meaning it is the payload of a send that is still outstanding. Reading a read-busy register does not stall.
- R5: A predicated instruction stalls while its flag register is write-busy. A flag write to a write-busy flag register also stalls. A flag writeback clears that flag's busy bit.
- R6: An indirectly addressed instruction stalls while its address register is write-busy. An address-register write to a write-busy address register also stalls. An address writeback clears that register's busy bit.
- R7: Marks are applied only when an instruction issues (`iss_valid` and `iss_ready` both high). An issued instruction marks its destination range, its flag write and its address write as write-busy. A send (`iss_send`=1) also marks its source range as read-busy. A stalled instruction marks nothing.
- R8: The clear inputs take effect at the next clock edge. A writeback clears write-busy bits over a range. A read-done clears read-busy bits over a range. In the cycle a clear is presented, `iss_ready` still reflects the old bits. If a bit is marked and cleared in the same cycle, the mark wins.
- R9: When `iss_no_check`=1, `iss_ready` is high whatever the busy bits say. The instruction still applies its marks.
- R10: When `iss_no_mark`=1, the instruction marks no destination, flag or address register busy. The payload of a send is still marked read-busy.
- R11: A range covers `len` consecutive registers starting at `base`. It wraps modulo the register count, so base 126 with length 4 covers 126, 127, 0 and 1. A length of 0 covers nothing.
- R12: Busy bits belong to one thread only. Marks, clears and stalls in one thread do not affect any other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered |
| iss_tid | input | TID_W | Thread of the offered instruction |
| iss_send | input | 1 | Instruction is a message send |
| iss_no_check | input | 1 | Hint: skip the hazard test |
| iss_no_mark | input | 1 | Hint: do not mark destinations busy |
| iss_srca_vld | input | 1 | Source A is used |
| iss_srca | input | REG_W | Source A register |
| iss_srcb_vld | input | 1 | Source B is used |
| iss_srcb | input | REG_W | Source B register |
| iss_pay_base | input | REG_W | First register of the source range (send payload) |
| iss_pay_len | input | LEN_W | Length of the source range |
| iss_dst_base | input | REG_W | First destination register |
| iss_dst_len | input | LEN_W | Number of destination registers |
| iss_pred_vld | input | 1 | Instruction is predicated |
| iss_pred_flag | input | FLG_W | Flag register read by the predicate |
| iss_fwr_vld | input | 1 | Instruction writes a flag register |
| iss_fwr_flag | input | FLG_W | Flag register written |
| iss_ind_vld | input | 1 | A source is addressed indirectly |
| iss_ind_addr | input | ADR_W | Address register used for indexing |
| iss_awr_vld | input | 1 | Instruction writes an address register |
| iss_awr_addr | input | ADR_W | Address register written |
| iss_ready | output | 1 | No hazard: the offered instruction issues |
| wb_valid | input | 1 | Result writeback, clears write-busy |
| wb_tid | input | TID_W | Writeback thread |
| wb_base | input | REG_W | First register written back |
| wb_len | input | LEN_W | Number of registers written back |
| rdn_valid | input | 1 | Payload read complete, clears read-busy |
| rdn_tid | input | TID_W | Read-done thread |
| rdn_base | input | REG_W | First payload register released |
| rdn_len | input | LEN_W | Number of payload registers released |
| fwb_valid | input | 1 | Flag writeback |
| fwb_tid | input | TID_W | Flag writeback thread |
| fwb_flag | input | FLG_W | Flag register written back |
| awb_valid | input | 1 | Address-register writeback |
| awb_tid | input | TID_W | Address writeback thread |
| awb_addr | input | ADR_W | Address register written back |

## Verification
A wrong busy bit has only two ways to show at the ports, and both appear in the same cycle the affected thread next offers an instruction that touches that register. A bit that is wrongly set shows as a held-low `iss_ready`. A bit that is lost shows as an issue that should have stalled. The bench therefore probes each mark and each clear with a read or a non-marking write offered one cycle later. It uses the other threads to show that a bit cannot leak between threads, and it probes range edges, including the wrap from the top register to register 0, to show that no bit past the end of a range is marked. Same-cycle mark and clear, and a clear presented together with a probe, pin down the one-cycle timing of the clear paths.

// File: rtl/sb_pkg.sv
package sb_pkg;

   // Hazard classes found by one thread's check
   typedef struct packed {
      logic raw;
      logic waw;
      logic war;
   } sb_hazard_t;

   // Index width for an array of n entries, never below one bit
   function automatic int sb_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sb_decode.sv
// Index to one-hot vector, gated by an enable
module sb_decode
   import sb_pkg::*;
#(
   parameter int N = 4,
   localparam int IW = sb_idx_w(N)
) (
   input  logic          en,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  oh
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign oh[i] = en && (idx == IW'(i));
   end
endmodule

// File: rtl/sb_range_mask.sv
// Mask of len consecutive registers from base, wrapping modulo N
module sb_range_mask
   import sb_pkg::*;
#(
   parameter int N     = 128,
   parameter int LEN_W = 4,
   localparam int IW   = sb_idx_w(N)
) (
   input  logic [IW-1:0]    base,
   input  logic [LEN_W-1:0] len,
   output logic [N-1:0]     mask
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [IW-1:0] off;
      assign off     = IW'(i) - base;
      assign mask[i] = (32'(off) < 32'(len));
   end
endmodule

// File: rtl/sb_thread_slot.sv
// Busy state and hazard test for a single thread
module sb_thread_slot
   import sb_pkg::*;
#(
   parameter int GRF_REGS   = 128,
   parameter int FLAG_REGS  = 4,
   parameter int ADDR_REGS  = 4,
   parameter bit READ_TRACK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   // offered instruction, already decoded to masks
   input  logic [GRF_REGS-1:0]  src_mask,
   input  logic [GRF_REGS-1:0]  dst_mask,
   input  logic [GRF_REGS-1:0]  pay_mask,
   input  logic [FLAG_REGS-1:0] pred_oh,
   input  logic [FLAG_REGS-1:0] fwr_oh,
   input  logic [ADDR_REGS-1:0] ind_oh,
   input  logic [ADDR_REGS-1:0] awr_oh,
   input  logic                 fire,
   input  logic                 is_send,
   input  logic                 no_mark,
   // clears addressed to this thread
   input  logic                 wb_en,
   input  logic [GRF_REGS-1:0]  wb_mask,
   input  logic                 rd_en,
   input  logic [GRF_REGS-1:0]  rd_mask,
   input  logic                 fwb_en,
   input  logic [FLAG_REGS-1:0] fwb_oh,
   input  logic                 awb_en,
   input  logic [ADDR_REGS-1:0] awb_oh,
   output sb_hazard_t           hz
);
   logic [GRF_REGS-1:0]  wbusy_q;
   logic [FLAG_REGS-1:0] fbusy_q;
   logic [ADDR_REGS-1:0] abusy_q;
   logic [GRF_REGS-1:0]  rbusy;
   logic                 mark;

   assign mark = fire && !no_mark;

   // write-busy state: clear first, then mark, so a mark wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbusy_q <= '0;
         fbusy_q <= '0;
         abusy_q <= '0;
      end else begin
         wbusy_q <= (wbusy_q & ~(wb_en  ? wb_mask : '0)) | (mark ? dst_mask : '0);
         fbusy_q <= (fbusy_q & ~(fwb_en ? fwb_oh  : '0)) | (mark ? fwr_oh   : '0);
         abusy_q <= (abusy_q & ~(awb_en ? awb_oh  : '0)) | (mark ? awr_oh   : '0);
      end
   end

   // read-busy state exists only when payload protection is built
   if (READ_TRACK) begin : g_rtrack
      logic [GRF_REGS-1:0] rbusy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rbusy_q <= '0;
         end else begin
            rbusy_q <= (rbusy_q & ~(rd_en ? rd_mask : '0))
                     | ((fire && is_send) ? pay_mask : '0);
         end
      end
      assign rbusy = rbusy_q;
   end else begin : g_no_rtrack
      assign rbusy = '0;
   end

   always_comb begin
      hz.raw = (|(wbusy_q & src_mask)) || (|(fbusy_q & pred_oh)) || (|(abusy_q & ind_oh));
      hz.waw = (|(wbusy_q & dst_mask)) || (|(fbusy_q & fwr_oh))  || (|(abusy_q & awr_oh));
      hz.war = |(rbusy & dst_mask);
   end
endmodule

// File: rtl/reg_scoreboard.sv
// Multi-thread register dependency scoreboard (top)
module reg_scoreboard
   import sb_pkg::*;
#(
   parameter int THREADS    = 7,
   parameter int GRF_REGS   = 128,
   parameter int FLAG_REGS  = 4,
   parameter int ADDR_REGS  = 4,
   parameter int MAX_LEN    = 8,
   parameter bit READ_TRACK = 1'b1,
   localparam int TID_W = sb_idx_w(THREADS),
   localparam int REG_W = sb_idx_w(GRF_REGS),
   localparam int LEN_W = $clog2(MAX_LEN + 1),
   localparam int FLG_W = sb_idx_w(FLAG_REGS),
   localparam int ADR_W = sb_idx_w(ADDR_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss_valid,
   input  logic [TID_W-1:0] iss_tid,
   input  logic             iss_send,
   input  logic             iss_no_check,
   input  logic             iss_no_mark,
   input  logic             iss_srca_vld,
   input  logic [REG_W-1:0] iss_srca,
   input  logic             iss_srcb_vld,
   input  logic [REG_W-1:0] iss_srcb,
   input  logic [REG_W-1:0] iss_pay_base,
   input  logic [LEN_W-1:0] iss_pay_len,
   input  logic [REG_W-1:0] iss_dst_base,
   input  logic [LEN_W-1:0] iss_dst_len,
   input  logic             iss_pred_vld,
   input  logic [FLG_W-1:0] iss_pred_flag,
   input  logic             iss_fwr_vld,
   input  logic [FLG_W-1:0] iss_fwr_flag,
   input  logic             iss_ind_vld,
   input  logic [ADR_W-1:0] iss_ind_addr,
   input  logic             iss_awr_vld,
   input  logic [ADR_W-1:0] iss_awr_addr,
   output logic             iss_ready,
   input  logic             wb_valid,
   input  logic [TID_W-1:0] wb_tid,
   input  logic [REG_W-1:0] wb_base,
   input  logic [LEN_W-1:0] wb_len,
   input  logic             rdn_valid,
   input  logic [TID_W-1:0] rdn_tid,
   input  logic [REG_W-1:0] rdn_base,
   input  logic [LEN_W-1:0] rdn_len,
   input  logic             fwb_valid,
   input  logic [TID_W-1:0] fwb_tid,
   input  logic [FLG_W-1:0] fwb_flag,
   input  logic             awb_valid,
   input  logic [TID_W-1:0] awb_tid,
   input  logic [ADR_W-1:0] awb_addr
);
   // elaboration-time parameter checks
   if (THREADS < 1) begin : g_bad_threads
      $error("reg_scoreboard: THREADS must be at least 1");
   end
   if (GRF_REGS != (1 << REG_W)) begin : g_bad_grf
      $error("reg_scoreboard: GRF_REGS must be a power of two");
   end
   if (MAX_LEN < 1 || MAX_LEN > GRF_REGS) begin : g_bad_len
      $error("reg_scoreboard: MAX_LEN out of range");
   end
   if (FLAG_REGS < 1 || ADDR_REGS < 1) begin : g_bad_arf
      $error("reg_scoreboard: flag and address register counts must be positive");
   end

   // shared decode of the offered instruction
   logic [GRF_REGS-1:0]  srca_oh, srcb_oh, pay_mask, dst_mask, src_mask;
   logic [GRF_REGS-1:0]  wb_mask, rd_mask;
   logic [FLAG_REGS-1:0] pred_oh, fwr_oh, fwb_oh;
   logic [ADDR_REGS-1:0] ind_oh, awr_oh, awb_oh;

   sb_decode #(.N(GRF_REGS)) u_dec_srca (.en(iss_srca_vld), .idx(iss_srca), .oh(srca_oh));
   sb_decode #(.N(GRF_REGS)) u_dec_srcb (.en(iss_srcb_vld), .idx(iss_srcb), .oh(srcb_oh));

   sb_range_mask #(.N(GRF_REGS), .LEN_W(LEN_W)) u_rng_pay
      (.base(iss_pay_base), .len(iss_pay_len), .mask(pay_mask));
   sb_range_mask #(.N(GRF_REGS), .LEN_W(LEN_W)) u_rng_dst
      (.base(iss_dst_base), .len(iss_dst_len), .mask(dst_mask));
   sb_range_mask #(.N(GRF_REGS), .LEN_W(LEN_W)) u_rng_wb
      (.base(wb_base), .len(wb_len), .mask(wb_mask));
   sb_range_mask #(.N(GRF_REGS), .LEN_W(LEN_W)) u_rng_rd
      (.base(rdn_base), .len(rdn_len), .mask(rd_mask));

   assign src_mask = srca_oh | srcb_oh | pay_mask;

   sb_decode #(.N(FLAG_REGS)) u_dec_pred (.en(iss_pred_vld), .idx(iss_pred_flag), .oh(pred_oh));
   sb_decode #(.N(FLAG_REGS)) u_dec_fwr  (.en(iss_fwr_vld),  .idx(iss_fwr_flag),  .oh(fwr_oh));
   sb_decode #(.N(FLAG_REGS)) u_dec_fwb  (.en(1'b1),         .idx(fwb_flag),      .oh(fwb_oh));
   sb_decode #(.N(ADDR_REGS)) u_dec_ind  (.en(iss_ind_vld),  .idx(iss_ind_addr),  .oh(ind_oh));
   sb_decode #(.N(ADDR_REGS)) u_dec_awr  (.en(iss_awr_vld),  .idx(iss_awr_addr),  .oh(awr_oh));
   sb_decode #(.N(ADDR_REGS)) u_dec_awb  (.en(1'b1),         .idx(awb_addr),      .oh(awb_oh));

   // thread selection
   logic [THREADS-1:0] iss_sel, wb_sel, rd_sel, fwb_sel, awb_sel;
   sb_decode #(.N(THREADS)) u_dec_tid  (.en(iss_valid), .idx(iss_tid), .oh(iss_sel));
   sb_decode #(.N(THREADS)) u_dec_wbt  (.en(wb_valid),  .idx(wb_tid),  .oh(wb_sel));
   sb_decode #(.N(THREADS)) u_dec_rdt  (.en(rdn_valid), .idx(rdn_tid), .oh(rd_sel));
   sb_decode #(.N(THREADS)) u_dec_fwbt (.en(fwb_valid), .idx(fwb_tid), .oh(fwb_sel));
   sb_decode #(.N(THREADS)) u_dec_awbt (.en(awb_valid), .idx(awb_tid), .oh(awb_sel));

   // one independent check per thread, issuing thread selected afterwards
   sb_hazard_t       hz [THREADS];
   logic [THREADS-1:0] hz_any;
   logic             fire;

   assign fire = iss_valid && iss_ready;

   for (genvar t = 0; t < THREADS; t++) begin : g_thread
      sb_thread_slot #(
         .GRF_REGS   (GRF_REGS),
         .FLAG_REGS  (FLAG_REGS),
         .ADDR_REGS  (ADDR_REGS),
         .READ_TRACK (READ_TRACK)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_mask (src_mask),
         .dst_mask (dst_mask),
         .pay_mask (pay_mask),
         .pred_oh  (pred_oh),
         .fwr_oh   (fwr_oh),
         .ind_oh   (ind_oh),
         .awr_oh   (awr_oh),
         .fire     (fire && iss_sel[t]),
         .is_send  (iss_send),
         .no_mark  (iss_no_mark),
         .wb_en    (wb_sel[t]),
         .wb_mask  (wb_mask),
         .rd_en    (rd_sel[t]),
         .rd_mask  (rd_mask),
         .fwb_en   (fwb_sel[t]),
         .fwb_oh   (fwb_oh),
         .awb_en   (awb_sel[t]),
         .awb_oh   (awb_oh),
         .hz       (hz[t])
      );
      assign hz_any[t] = hz[t].raw || hz[t].waw || hz[t].war;
   end

   // iss_sel is zero for an out-of-range thread tag, so nothing stalls or marks
   assign iss_ready = iss_no_check || !(|(hz_any & iss_sel));

endmodule

// File: rtl/reg_scoreboard_chk.sv
// Port-level properties of the scoreboard, bound to the top module
module reg_scoreboard_chk #(
   parameter int TID_W = 3,
   parameter int REG_W = 7,
   parameter int LEN_W = 4,
   parameter int FLG_W = 2,
   parameter int ADR_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic [TID_W-1:0] iss_tid,
   input logic             iss_send,
   input logic             iss_no_check,
   input logic             iss_no_mark,
   input logic             iss_srca_vld,
   input logic [REG_W-1:0] iss_srca,
   input logic             iss_srcb_vld,
   input logic [REG_W-1:0] iss_pay_base,
   input logic [LEN_W-1:0] iss_pay_len,
   input logic [REG_W-1:0] iss_dst_base,
   input logic [LEN_W-1:0] iss_dst_len,
   input logic             iss_pred_vld,
   input logic [FLG_W-1:0] iss_pred_flag,
   input logic             iss_fwr_vld,
   input logic [FLG_W-1:0] iss_fwr_flag,
   input logic             iss_ind_vld,
   input logic             iss_awr_vld,
   input logic             iss_ready
);
   logic fire;
   assign fire = iss_valid && iss_ready;

   // R9: skipping the check always lets the instruction go
   a_r9_no_check_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_no_check) |-> iss_ready);

   // R11: an instruction that touches no register can never stall
   a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_srca_vld && !iss_srcb_vld && iss_pay_len == '0 &&
       iss_dst_len == '0 && !iss_pred_vld && !iss_fwr_vld && !iss_ind_vld &&
       !iss_awr_vld) |-> iss_ready);

   // R2: reading a register marked by the previous issue of the same thread stalls
   a_r2_raw_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_no_check && iss_srca_vld && $past(rst_n) &&
       $past(fire && !iss_no_mark && iss_dst_len != '0) &&
       iss_tid == $past(iss_tid) && iss_srca == $past(iss_dst_base)) |-> !iss_ready);

   // R5: a predicate on a flag just written by the same thread stalls
   a_r5_flag_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_no_check && iss_pred_vld && $past(rst_n) &&
       $past(fire && !iss_no_mark && iss_fwr_vld) &&
       iss_tid == $past(iss_tid) && iss_pred_flag == $past(iss_fwr_flag)) |-> !iss_ready);

   // R4: overwriting the payload of a send issued last cycle stalls
   a_r4_war_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_no_check && iss_dst_len != '0 && $past(rst_n) &&
       $past(fire && iss_send && iss_pay_len != '0) &&
       iss_tid == $past(iss_tid) && iss_dst_base == $past(iss_pay_base)) |-> !iss_ready);

endmodule

bind reg_scoreboard reg_scoreboard_chk #(
   .TID_W (TID_W),
   .REG_W (REG_W),
   .LEN_W (LEN_W),
   .FLG_W (FLG_W),
   .ADR_W (ADR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .iss_valid     (iss_valid),
   .iss_tid       (iss_tid),
   .iss_send      (iss_send),
   .iss_no_check  (iss_no_check),
   .iss_no_mark   (iss_no_mark),
   .iss_srca_vld  (iss_srca_vld),
   .iss_srca      (iss_srca),
   .iss_srcb_vld  (iss_srcb_vld),
   .iss_pay_base  (iss_pay_base),
   .iss_pay_len   (iss_pay_len),
   .iss_dst_base  (iss_dst_base),
   .iss_dst_len   (iss_dst_len),
   .iss_pred_vld  (iss_pred_vld),
   .iss_pred_flag (iss_pred_flag),
   .iss_fwr_vld   (iss_fwr_vld),
   .iss_fwr_flag  (iss_fwr_flag),
   .iss_ind_vld   (iss_ind_vld),
   .iss_awr_vld   (iss_awr_vld),
   .iss_ready     (iss_ready)
);

// File: tb/reg_scoreboard_tb.sv
module reg_scoreboard_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       iss_valid, iss_send, iss_no_check, iss_no_mark;
   logic [2:0] iss_tid;
   logic       iss_srca_vld, iss_srcb_vld;
   logic [6:0] iss_srca, iss_srcb, iss_pay_base, iss_dst_base;
   logic [3:0] iss_pay_len, iss_dst_len;
   logic       iss_pred_vld, iss_fwr_vld, iss_ind_vld, iss_awr_vld;
   logic [1:0] iss_pred_flag, iss_fwr_flag, iss_ind_addr, iss_awr_addr;
   logic       iss_ready;
   logic       wb_valid, rdn_valid, fwb_valid, awb_valid;
   logic [2:0] wb_tid, rdn_tid, fwb_tid, awb_tid;
   logic [6:0] wb_base, rdn_base;
   logic [3:0] wb_len, rdn_len;
   logic [1:0] fwb_flag, awb_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   reg_scoreboard u_dut (.*);

   // vector: op[28:26] tid[25:23] a[22:16] b[15:9] len[8:5] exp[4] req[3:0]
   localparam logic [2:0] OP_ALU = 3'd0, OP_SEND = 3'd1, OP_READ = 3'd2,
                          OP_WPRB = 3'd3, OP_WB = 3'd4, OP_RDN = 3'd5;
   localparam int NV = 27;
   localparam logic [28:0] VEC [NV] = '{
      {OP_READ, 3'd0, 7'd5,   7'd0,  4'd0, 1'b1, 4'd1 },  // R1 clean after reset
      {OP_ALU,  3'd0, 7'd5,   7'd1,  4'd1, 1'b1, 4'd7 },  // R7 marks r5
      {OP_READ, 3'd0, 7'd5,   7'd0,  4'd0, 1'b0, 4'd2 },  // R2
      {OP_READ, 3'd1, 7'd5,   7'd0,  4'd0, 1'b1, 4'd12},  // R12 other thread
      {OP_WPRB, 3'd0, 7'd5,   7'd0,  4'd1, 1'b0, 4'd3 },  // R3
      {OP_WB,   3'd0, 7'd5,   7'd0,  4'd1, 1'b0, 4'd8 },
      {OP_READ, 3'd0, 7'd5,   7'd0,  4'd0, 1'b1, 4'd8 },  // R8 cleared
      {OP_SEND, 3'd2, 7'd20,  7'd40, 4'd4, 1'b1, 4'd7 },  // R7 send
      {OP_READ, 3'd2, 7'd23,  7'd0,  4'd0, 1'b0, 4'd11},  // R11 range end
      {OP_READ, 3'd2, 7'd24,  7'd0,  4'd0, 1'b1, 4'd11},  // R11 past end
      {OP_WPRB, 3'd2, 7'd42,  7'd0,  4'd1, 1'b0, 4'd4 },  // R4 WAR
      {OP_READ, 3'd2, 7'd42,  7'd0,  4'd0, 1'b1, 4'd4 },  // R4 read ok
      {OP_RDN,  3'd2, 7'd40,  7'd0,  4'd4, 1'b0, 4'd8 },
      {OP_WPRB, 3'd2, 7'd42,  7'd0,  4'd1, 1'b1, 4'd8 },  // R8 read-done
      {OP_WB,   3'd2, 7'd20,  7'd0,  4'd4, 1'b0, 4'd8 },
      {OP_READ, 3'd2, 7'd23,  7'd0,  4'd0, 1'b1, 4'd8 },  // R8
      {OP_ALU,  3'd3, 7'd126, 7'd64, 4'd4, 1'b1, 4'd11},  // R11 wrap
      {OP_READ, 3'd3, 7'd1,   7'd0,  4'd0, 1'b0, 4'd11},  // R11
      {OP_READ, 3'd3, 7'd2,   7'd0,  4'd0, 1'b1, 4'd11},  // R11
      {OP_WB,   3'd3, 7'd126, 7'd0,  4'd4, 1'b0, 4'd8 },
      {OP_READ, 3'd3, 7'd0,   7'd0,  4'd0, 1'b1, 4'd8 },  // R8 wrap clear
      {OP_ALU,  3'd4, 7'd7,   7'd2,  4'd1, 1'b1, 4'd7 },
      {OP_ALU,  3'd4, 7'd8,   7'd7,  4'd1, 1'b0, 4'd2 },  // R2 via source A
      {OP_READ, 3'd4, 7'd8,   7'd0,  4'd0, 1'b1, 4'd7 },  // R7 stalled marks nothing
      {OP_WB,   3'd4, 7'd7,   7'd0,  4'd1, 1'b0, 4'd8 },
      {OP_ALU,  3'd4, 7'd8,   7'd7,  4'd1, 1'b1, 4'd8 },
      {OP_WB,   3'd4, 7'd8,   7'd0,  4'd1, 1'b0, 4'd8 }
   };

   task automatic idle_in();
      iss_valid = 0; iss_tid = 0; iss_send = 0; iss_no_check = 0; iss_no_mark = 0;
      iss_srca_vld = 0; iss_srca = 0; iss_srcb_vld = 0; iss_srcb = 0;
      iss_pay_base = 0; iss_pay_len = 0; iss_dst_base = 0; iss_dst_len = 0;
      iss_pred_vld = 0; iss_pred_flag = 0; iss_fwr_vld = 0; iss_fwr_flag = 0;
      iss_ind_vld = 0; iss_ind_addr = 0; iss_awr_vld = 0; iss_awr_addr = 0;
      wb_valid = 0; wb_tid = 0; wb_base = 0; wb_len = 0;
      rdn_valid = 0; rdn_tid = 0; rdn_base = 0; rdn_len = 0;
      fwb_valid = 0; fwb_tid = 0; fwb_flag = 0;
      awb_valid = 0; awb_tid = 0; awb_addr = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle_in();
   endtask

   task automatic chk(input logic exp, input string tag);
      #1;
      checks++;
      if (iss_ready !== exp) begin
         errors++;
         $display("FAIL %s: iss_ready=%b expected %b", tag, iss_ready, exp);
      end
   endtask

   task automatic read(input logic [2:0] t, input logic [6:0] r);
      iss_valid = 1; iss_tid = t; iss_srca_vld = 1; iss_srca = r;
   endtask

   task automatic alu(input logic [2:0] t, input logic [6:0] d, input logic [3:0] l);
      iss_valid = 1; iss_tid = t; iss_dst_base = d; iss_dst_len = l;
   endtask

   task automatic wb(input logic [2:0] t, input logic [6:0] b, input logic [3:0] l);
      wb_valid = 1; wb_tid = t; wb_base = b; wb_len = l;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      idle_in();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         v = VEC[i];
         step();
         case (v[28:26])
            OP_ALU:  begin alu(v[25:23], v[22:16], v[8:5]);
                        iss_srca_vld = 1; iss_srca = v[15:9]; end
            OP_SEND: begin alu(v[25:23], v[22:16], v[8:5]); iss_send = 1;
                        iss_pay_base = v[15:9]; iss_pay_len = v[8:5]; end
            OP_READ: read(v[25:23], v[22:16]);
            OP_WPRB: begin alu(v[25:23], v[22:16], v[8:5]); iss_no_mark = 1; end
            OP_WB:   wb(v[25:23], v[22:16], v[8:5]);
            default: begin rdn_valid = 1; rdn_tid = v[25:23];
                        rdn_base = v[22:16]; rdn_len = v[8:5]; end
         endcase
         if (v[28:26] <= OP_WPRB)
            chk(v[4], $sformatf("R%0d vector %0d", v[3:0], i));
      end

      // R8: mark and clear in the same cycle, mark wins; clear visible one cycle later
      step(); alu(3'd5, 7'd9, 4'd1); wb(3'd5, 7'd9, 4'd1); chk(1'b1, "R8 issue with clear");
      step(); read(3'd5, 7'd9); wb(3'd5, 7'd9, 4'd1); chk(1'b0, "R8 mark wins, clear pending");
      step(); read(3'd5, 7'd9); chk(1'b1, "R8 clear applied");

      // R5: flag registers
      step(); iss_valid = 1; iss_tid = 1; iss_fwr_vld = 1; iss_fwr_flag = 2; chk(1'b1, "R5 flag write");
      step(); iss_valid = 1; iss_tid = 1; iss_pred_vld = 1; iss_pred_flag = 2; chk(1'b0, "R5 predicate stall");
      step(); iss_valid = 1; iss_tid = 1; iss_fwr_vld = 1; iss_fwr_flag = 2; iss_no_mark = 1;
      chk(1'b0, "R5 flag WAW stall");
      step(); iss_valid = 1; iss_tid = 1; iss_pred_vld = 1; iss_pred_flag = 1; chk(1'b1, "R5 other flag");
      step(); fwb_valid = 1; fwb_tid = 1; fwb_flag = 2;
      step(); iss_valid = 1; iss_tid = 1; iss_pred_vld = 1; iss_pred_flag = 2; chk(1'b1, "R5 after flag writeback");

      // R6: address registers
      step(); iss_valid = 1; iss_tid = 6; iss_awr_vld = 1; iss_awr_addr = 3; chk(1'b1, "R6 address write");
      step(); iss_valid = 1; iss_tid = 6; iss_ind_vld = 1; iss_ind_addr = 3; chk(1'b0, "R6 indirect stall");
      step(); iss_valid = 1; iss_tid = 6; iss_awr_vld = 1; iss_awr_addr = 3; iss_no_mark = 1;
      chk(1'b0, "R6 address WAW stall");
      step(); awb_valid = 1; awb_tid = 6; awb_addr = 3;
      step(); iss_valid = 1; iss_tid = 6; iss_ind_vld = 1; iss_ind_addr = 3; chk(1'b1, "R6 after writeback");

      // R9: skip-check hint
      step(); alu(3'd0, 7'd50, 4'd1); chk(1'b1, "R9 setup");
      step(); read(3'd0, 7'd50); iss_dst_base = 7'd60; iss_dst_len = 1; iss_no_check = 1;
      chk(1'b1, "R9 forced issue");
      step(); read(3'd0, 7'd60); chk(1'b0, "R9 forced issue still marks");
      step(); wb(3'd0, 7'd50, 4'd1);
      step(); wb(3'd0, 7'd60, 4'd1);

      // R10: no-mark hint
      step(); alu(3'd0, 7'd70, 4'd1); iss_no_mark = 1; chk(1'b1, "R10 unmarked issue");
      step(); read(3'd0, 7'd70); chk(1'b1, "R10 destination not busy");
      step(); alu(3'd0, 7'd80, 4'd2); iss_send = 1; iss_no_mark = 1;
      iss_pay_base = 7'd90; iss_pay_len = 2; chk(1'b1, "R10 unmarked send");
      step(); read(3'd0, 7'd80); chk(1'b1, "R10 send destination not busy");
      step(); alu(3'd0, 7'd91, 4'd1); iss_no_mark = 1; chk(1'b0, "R10 payload still read-busy");
      step(); iss_valid = 1; iss_fwr_vld = 1; iss_fwr_flag = 0; iss_no_mark = 1; chk(1'b1, "R10 flag write");
      step(); iss_valid = 1; iss_pred_vld = 1; iss_pred_flag = 0; chk(1'b1, "R10 flag not busy");
      step(); rdn_valid = 1; rdn_tid = 0; rdn_base = 7'd90; rdn_len = 2;

      // R11: zero length marks nothing
      step(); alu(3'd0, 7'd100, 4'd0); chk(1'b1, "R11 zero-length issue");
      step(); alu(3'd0, 7'd100, 4'd1); iss_no_mark = 1; chk(1'b1, "R11 zero-length marked nothing");

      // R1: reset clears marks
      step(); alu(3'd0, 7'd33, 4'd1); chk(1'b1, "R1 mark before reset");
      step(); rst_n = 0;
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 1;
      step(); read(3'd0, 7'd33); chk(1'b1, "R1 reset cleared mark");

      step();
      finish_run();
   end
endmodule